// File: doc/BRIEF.md
# GPIO Port with Analog Channel Override

An eight-pin general-purpose I/O port controller that sits on a simple CPU register bus. Two registers are mapped on the bus: an output latch and a per-pin direction register. Each direction bit turns its pin's output driver on or off. A read of the latch address returns, for each pin, either the latch bit (output pins) or the synchronised pin level (input pins). Every pin input passes through a two-flop synchroniser before it reaches the read path.

A converter's control logic can claim one pin as an analog input. It does this with an enable and a 3-bit channel index. The claimed pin has its driver turned off, whatever its direction bit holds. Its digital read path is masked to zero, so no digital sampling happens on an analog level. Reset clears the direction register so that all pins start as inputs. Reset leaves the output latch alone. Software can therefore preload the latch and only then turn a pin into an output, without a glitch.

Top module: `gpio_analog_port`

## Requirements
- R1: With no analog override, pinOe[i] is 1 exactly when direction bit i is 1, and 0 when it is 0.
- R2: A read of the latch address (0x0441) returns latch bit i for every pin whose direction bit is 1.
- R3: For a pin whose direction bit is 0, a latch-address read returns the pin level through a two-flop synchroniser. A level applied before a rising edge is not visible after that one edge, and is visible after the second edge.
- R4: The latch accepts writes whatever the direction bits hold. pinOut always presents the latch, one cycle after the write.
- R5: Reset clears all direction bits. After reset, pinOe is 0 and a read of the direction address returns 0.
- R6: Reset does not alter the latch. A value written before reset reads back, and drives pinOut, after reset.
- R7: Only addresses 0x0441 (latch) and 0x0445 (direction) are decoded. Writes to any other address change nothing. Reads of other addresses, and any cycle with busRdEn low, give busRdData = 0.
- R8: With anaEn = 1, the pin numbered by anaChan (0..7) has pinOe = 0 whatever its direction bit holds. Its bit in a latch-address read is 0.
- R9: With anaEn = 0, no pin is overridden, whatever anaChan holds. Pins not selected keep normal behaviour.
- R10: A read of the direction address returns the stored direction bits, unaffected by any analog override.
- R11: Writing the latch and then setting direction bits to 1 leaves pinOut unchanged across the direction write. The pin then drives the written value with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational, 0 when not reading a mapped register) |
| anaEn | input | 1 | Analog conversion enable from the converter control |
| anaChan | input | 3 | Pin index claimed as analog input |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output values to the pad drivers |
| pinOe | output | 8 | Per-pin output driver enables |

## Verification
The bench builds the port with its default parameters: eight pins, a two-stage synchroniser and the two register offsets at 0x0441 and 0x0445. With eight pins, the 3-bit channel index reaches every pin. The vectors claim channels 0, 3 and 7, which covers both ends of the index range as well as a middle pin. The two-stage depth makes the one-edge-versus-two-edge check of R3 exact. The fixed offsets allow a neighbouring unmapped address (0x0442 and 0x0443) to be probed for decode leaks.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // One-cycle strobes from the bus decoder to the datapath
  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic dataRd;
    logic dirRd;
  } gpio_strb_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DATA_OFS = 16'h0441,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 16'h0445
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output gpio_strb_t        strb
);
  logic hitData, hitDir;

  always_comb begin
    hitData     = (busAddr == DATA_OFS);
    hitDir      = (busAddr == DIR_OFS);
    strb.dataWr = busWrEn && hitData;
    strb.dirWr  = busWrEn && hitDir;
    strb.dataRd = busRdEn && hitData;
    strb.dirRd  = busRdEn && hitDir;
  end

  // R7: a single access decodes to at most one read and one write target
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.dataWr, strb.dirWr}) <= 1 && $onehot0({strb.dataRd, strb.dirRd}));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpio_strb_t       strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             anaEn,
  input  logic [CH_W-1:0]  anaChan,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] anaMask;
  logic [WIDTH-1:0] pinView;

  // Output latch: no reset, writable at any time
  always_ff @(posedge clk) begin
    if (strb.dataWr) latchQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dirQ <= '0;
    else if (strb.dirWr) dirQ <= wrData;
  end

  // Input synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
    for (genvar i = 0; i < WIDTH; i++) begin : g_ana
      assign anaMask[i] = anaEn && (anaChan == CH_W'(i));
    end
  endgenerate

  always_comb begin
    pinView = ((latchQ & dirQ) | (syncQ[SYNC_STAGES-1] & ~dirQ)) & ~anaMask;
    pinOut  = latchQ;
    pinOe   = dirQ & ~anaMask;
    rdData  = '0;
    if (strb.dataRd)     rdData = pinView;
    else if (strb.dirRd) rdData = dirQ;
  end

  // R11: a direction write never disturbs the driven value
  p_dir_wr_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> $stable(pinOut));
  // R4: a latch write appears on pinOut one cycle later
  p_latch_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> pinOut == $past(wrData));
  // R1: after a direction write, only pins written with 1 may drive
  p_oe_subset_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> (pinOe & ~$past(wrData)) == '0);
  // R10: a direction read returns exactly the enables plus any overridden bit
  p_dir_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirRd |-> (rdData & ~anaMask) == pinOe);
endmodule

// File: rtl/gpio_analog_port.sv
module gpio_analog_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_OFS = 16'h0441,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 16'h0445,
  localparam int CH_W       = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              anaEn,
  input  logic [CH_W-1:0]   anaChan,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe
);
  gpio_strb_t strb;

  gpio_ctrl #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb));

  gpio_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .anaEn(anaEn), .anaChan(anaChan), .pinIn(pinIn),
    .rdData(busRdData), .pinOut(pinOut), .pinOe(pinOe));

  // R8: the claimed pin never drives
  p_ana_no_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    anaEn |-> !pinOe[anaChan]);
  // R7: nothing is returned without a read strobe
  p_idle_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> busRdData == '0);
endmodule

// File: tb/gpio_analog_port_test.sv
`timescale 1ns/1ps
module gpio_analog_port_test;
  localparam logic [15:0] A_DATA = 16'h0441;
  localparam logic [15:0] A_DIR  = 16'h0445;

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 0, busRdEn = 0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        anaEn = 0;
  logic [2:0]  anaChan = '0;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut, pinOe;

  int checks = 0, fails = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  gpio_analog_port uut (.*);

  // {dir, latch, pin, anaEn, chan, expected data read, expected oe}
  typedef struct packed {
    logic [7:0] dir; logic [7:0] lat; logic [7:0] pin;
    logic ana; logic [2:0] ch; logic [7:0] expRd; logic [7:0] expOe;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hA5, 8'h3C, 1'b0, 3'd0, 8'hA5, 8'hFF},
    '{8'h00, 8'hA5, 8'h3C, 1'b0, 3'd0, 8'h3C, 8'h00},
    '{8'hF0, 8'h12, 8'hAB, 1'b0, 3'd5, 8'h1B, 8'hF0},
    '{8'hFF, 8'h5A, 8'h00, 1'b1, 3'd3, 8'h52, 8'hF7},
    '{8'h0F, 8'h00, 8'hFF, 1'b1, 3'd7, 8'h70, 8'h0F},
    '{8'h55, 8'hFF, 8'h00, 1'b1, 3'd0, 8'h54, 8'h54}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1;
    #1 d = busRdData;
    busRdEn = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 oe in reset", pinOe, 8'h00);
    rstN = 1;
    busRead(A_DIR, rd);
    check("R5 dir after reset", rd, 8'h00);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      anaEn = 0;
      pinIn = VECS[v].pin;
      busWrite(A_DATA, VECS[v].lat);
      busWrite(A_DIR, VECS[v].dir);
      anaEn = VECS[v].ana; anaChan = VECS[v].ch;
      repeat (3) @(negedge clk);
      busRead(A_DATA, rd);
      check("R2/R3/R8 data read", rd, VECS[v].expRd);
      check("R1/R8 oe", pinOe, VECS[v].expOe);
      check("R4 pinOut", pinOut, VECS[v].lat);
      busRead(A_DIR, rd);
      check("R10 dir read", rd, VECS[v].dir);
    end
    anaEn = 0;

    // R9: channel held but enable low
    busWrite(A_DIR, 8'hFF);
    anaChan = 3'd5;
    @(negedge clk); #1;
    check("R9 no override", pinOe, 8'hFF);

    // R3: synchroniser depth
    busWrite(A_DIR, 8'h00);
    pinIn = 8'h00;
    repeat (3) @(negedge clk);
    busAddr = A_DATA; busRdEn = 1;
    pinIn = 8'h81;
    @(negedge clk); #1;
    check("R3 one edge", busRdData, 8'h00);
    @(negedge clk); #1;
    check("R3 two edges", busRdData, 8'h81);
    busRdEn = 0;
    @(negedge clk); #1;
    check("R7 idle read", busRdData, 8'h00);

    // R7: unmapped addresses
    busWrite(A_DIR, 8'h0F);
    busWrite(16'h0443, 8'hF0);
    busWrite(16'h0442, 8'h77);
    busRead(A_DIR, rd);
    check("R7 dir untouched", rd, 8'h0F);
    check("R7 latch untouched", pinOut, 8'hFF);
    busRead(16'h0442, rd);
    check("R7 unmapped read", rd, 8'h00);

    // R4: latch write while pins are inputs
    busWrite(A_DIR, 8'h00);
    busWrite(A_DATA, 8'hC3);
    check("R4 latch with dir 0", pinOut, 8'hC3);

    // R11: preload then enable; pinOut unchanged around direction write
    @(negedge clk);
    busAddr = A_DIR; busWrData = 8'hFF; busWrEn = 1;
    #1 check("R11 before dir write", pinOut, 8'hC3);
    @(negedge clk);
    busWrEn = 0;
    #1 check("R11 after dir write", pinOut, 8'hC3);
    check("R11 oe on", pinOe, 8'hFF);

    // R6: reset keeps latch, clears direction
    busWrite(A_DATA, 8'h3C);
    @(negedge clk); rstN = 0;
    @(negedge clk); #1;
    check("R5 oe cleared", pinOe, 8'h00);
    rstN = 1;
    check("R6 latch kept on pins", pinOut, 8'h3C);
    busWrite(A_DIR, 8'hFF);
    busRead(A_DATA, rd);
    check("R6 latch kept on read", rd, 8'h3C);

    finish_run();
  end
endmodule